// File: doc/BRIEF.md
# I2C Stuck-Line Recovery Sequencer

This block runs once, on a start pulse, before an I2C controller is enabled. A peripheral can hold SCL or SDA low after a reset cuts a transfer short. The sequencer takes both pads into a general-purpose pin function and inspects SCL and then SDA. A line that already reads high is left alone. A line that reads low is driven high and polled at a fixed interval until it reads high or a poll limit is reached. The sequencer then releases the line and reads it again.

When both lines have been handled, the pads are handed back to the I2C controller. The block reports the following results, which hold until the next start:
- per-line flags for a line found stuck and for a line that stayed stuck;
- the number of polls each freed line needed;
- an overall verdict, given only when something was found stuck.

The poll interval is a cycle count computed from the clock frequency. A multi-stage synchronizer on the pad inputs has settled before every sample is taken.

Top module: `i2c_line_rescue`

## Requirements
- R1: Lines are handled one at a time, SCL (index 0) first and then SDA (index 1). The two output drivers are never enabled together.
- R2: A line that reads high at its first sample is not flagged bad, is never driven, and its poll count stays 0.
- R3: A line that reads low at its first sample sets its bad flag. Its drive value is high in the cycle before its driver turns on and in every cycle the driver is on.
- R4: While a line is driven, it is polled once every POLL_CYC = (CLK_HZ/1e6)*POLL_US cycles, for at most POLL_LIMIT polls. Polling ends at the first poll that reads high.
- R5: When polling ends for either reason, the line's driver is switched off. After completion both drivers are off.
- R6: After release the line is sampled again. If it is still low, its failed flag is set and its poll count stays 0. Otherwise its poll count equals the number of polls taken (1 to POLL_LIMIT). A failed flag is never set without the bad flag.
- R7: pad_sel_i2c is 0 (general-purpose pin function) after reset and during recovery, with drivers off outside the drive window. It becomes 1 (I2C controller) at completion. No driver is on while it is 1.
- R8: status_valid is 1 after completion only when at least one line was bad. status_ok is 1 only when status_valid is 1 and no line failed.
- R9: A start pulse while idle raises busy in the next cycle. done is high for exactly one cycle, in the cycle busy falls.
- R10: A start pulse while busy is ignored. The run finishes with its own results and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin recovery |
| scl_in | input | 1 | Level read back from the SCL pad |
| sda_in | input | 1 | Level read back from the SDA pad |
| scl_oe | output | 1 | SCL pad driver enable |
| scl_out | output | 1 | SCL pad drive value |
| sda_oe | output | 1 | SDA pad driver enable |
| sda_out | output | 1 | SDA pad drive value |
| pad_sel_i2c | output | 1 | 1 = pads owned by the I2C controller, 0 = pin function |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| bad | output | 2 | Per-line stuck-low flag, bit 0 SCL, bit 1 SDA |
| failed | output | 2 | Per-line still-low-after-release flag, bit 0 SCL, bit 1 SDA |
| scl_polls | output | $clog2(POLL_LIMIT+1) | Polls SCL needed to come free |
| sda_polls | output | $clog2(POLL_LIMIT+1) | Polls SDA needed to come free |
| status_valid | output | 1 | An overall verdict is present |
| status_ok | output | 1 | Verdict: every stuck line was freed |

## Verification
busy follows start by one clock, so the bench samples it on the falling edge after the start pulse. All flags, counts, the verdict and the pad hand-back are registered together with the one-cycle done pulse. The bench waits for the falling edge on which done is high and compares every result there. It checks idleness and driver release a few cycles later. The bench's peripheral model releases a stuck line in the middle of a chosen poll interval. This keeps each expected poll count clear of the synchronizer's two- to three-cycle latency.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   localparam int LRS_LINES = 2;
   localparam int LRS_SCL   = 0;
   localparam int LRS_SDA   = 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CHECK,
      ST_ARM,
      ST_DRIVE,
      ST_RSETTLE,
      ST_RECHECK,
      ST_NEXT,
      ST_FINISH
   } lrs_state_e;
endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[0] <= '1;
      else        pipe_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q[s] <= '1;
         else        pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/lrs_interval.sv
module lrs_interval #(
   parameter int PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (PERIOD == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int TW = $clog2(PERIOD);
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt_q <= '0;
         else if (!run)                      cnt_q <= '0;
         else if (cnt_q == TW'(PERIOD - 1))  cnt_q <= '0;
         else                                cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == TW'(PERIOD - 1));
   end
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
   import lrs_pkg::*;
#(
   parameter int POLL_LIMIT = 100,
   parameter int SETTLE     = 3,
   parameter int CW         = $clog2(POLL_LIMIT + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [LRS_LINES-1:0]         level,
   input  logic                         tick,
   output logic                         timer_run,
   output logic [LRS_LINES-1:0]         oe,
   output logic [LRS_LINES-1:0]         drv,
   output logic                         pad_sel_i2c,
   output logic                         busy,
   output logic                         done,
   output logic [LRS_LINES-1:0]         bad,
   output logic [LRS_LINES-1:0]         failed,
   output logic [LRS_LINES-1:0][CW-1:0] polls,
   output logic                         status_valid,
   output logic                         status_ok
);
   localparam int WW = $clog2(SETTLE + 1);

   lrs_state_e                  state_q;
   logic                        idx_q;
   logic [WW-1:0]               wait_q;
   logic [CW-1:0]               pcnt_q;
   logic [LRS_LINES-1:0]        oe_q, drv_q, bad_q, fail_q;
   logic [LRS_LINES-1:0][CW-1:0] res_q;
   logic                        pad_q, busy_q, done_q, sv_q, sok_q;
   logic                        settled;

   assign settled = (wait_q == WW'(SETTLE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= 1'b0;
         wait_q  <= '0;
         pcnt_q  <= '0;
         oe_q    <= '0;
         drv_q   <= '0;
         bad_q   <= '0;
         fail_q  <= '0;
         res_q   <= '0;
         pad_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         sv_q    <= 1'b0;
         sok_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  busy_q  <= 1'b1;
                  pad_q   <= 1'b0;
                  bad_q   <= '0;
                  fail_q  <= '0;
                  res_q   <= '0;
                  sv_q    <= 1'b0;
                  sok_q   <= 1'b0;
                  drv_q   <= '0;
                  idx_q   <= 1'b0;
                  wait_q  <= '0;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settled) begin
                  wait_q  <= '0;
                  state_q <= ST_CHECK;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ST_CHECK: begin
               if (level[idx_q]) begin
                  state_q <= ST_NEXT;
               end else begin
                  bad_q[idx_q] <= 1'b1;
                  drv_q[idx_q] <= 1'b1;
                  state_q      <= ST_ARM;
               end
            end
            ST_ARM: begin
               oe_q[idx_q] <= 1'b1;
               pcnt_q      <= '0;
               state_q     <= ST_DRIVE;
            end
            ST_DRIVE: begin
               if (tick) begin
                  pcnt_q <= pcnt_q + 1'b1;
                  if (level[idx_q] || (pcnt_q == CW'(POLL_LIMIT - 1))) begin
                     oe_q[idx_q] <= 1'b0;
                     wait_q      <= '0;
                     state_q     <= ST_RSETTLE;
                  end
               end
            end
            ST_RSETTLE: begin
               if (settled) begin
                  wait_q  <= '0;
                  state_q <= ST_RECHECK;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            ST_RECHECK: begin
               if (!level[idx_q]) fail_q[idx_q] <= 1'b1;
               else               res_q[idx_q]  <= pcnt_q;
               state_q <= ST_NEXT;
            end
            ST_NEXT: begin
               if (idx_q == 1'(LRS_LINES - 1)) begin
                  state_q <= ST_FINISH;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  wait_q  <= '0;
                  state_q <= ST_SETTLE;
               end
            end
            ST_FINISH: begin
               pad_q   <= 1'b1;
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               sv_q    <= |bad_q;
               sok_q   <= (|bad_q) & ~(|fail_q);
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign timer_run    = (state_q == ST_DRIVE);
   assign oe           = oe_q;
   assign drv          = drv_q;
   assign pad_sel_i2c  = pad_q;
   assign busy         = busy_q;
   assign done         = done_q;
   assign bad          = bad_q;
   assign failed       = fail_q;
   assign polls        = res_q;
   assign status_valid = sv_q;
   assign status_ok    = sok_q;
endmodule

// File: rtl/i2c_line_rescue.sv
module i2c_line_rescue
   import lrs_pkg::*;
#(
   parameter int CLK_HZ      = 125_000_000,
   parameter int POLL_US     = 100,
   parameter int POLL_LIMIT  = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic                              scl_in,
   input  logic                              sda_in,
   output logic                              scl_oe,
   output logic                              scl_out,
   output logic                              sda_oe,
   output logic                              sda_out,
   output logic                              pad_sel_i2c,
   output logic                              busy,
   output logic                              done,
   output logic [1:0]                        bad,
   output logic [1:0]                        failed,
   output logic [$clog2(POLL_LIMIT+1)-1:0]   scl_polls,
   output logic [$clog2(POLL_LIMIT+1)-1:0]   sda_polls,
   output logic                              status_valid,
   output logic                              status_ok
);
   localparam int POLL_CYC = (CLK_HZ / 1_000_000) * POLL_US;
   localparam int SETTLE   = SYNC_STAGES + 1;
   localparam int CW       = $clog2(POLL_LIMIT + 1);

   if (CLK_HZ < 1_000_000) begin : g_bad_clk
      $error("CLK_HZ must be at least 1 MHz");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 1");
   end
   if (POLL_CYC <= SETTLE) begin : g_bad_interval
      $error("poll interval must exceed synchronizer settle time");
   end

   logic [LRS_LINES-1:0]         pad_raw, level, oe, drv;
   logic                         tick, timer_run;
   logic [LRS_LINES-1:0][CW-1:0] polls;

   assign pad_raw[LRS_SCL] = scl_in;
   assign pad_raw[LRS_SDA] = sda_in;

   lrs_sync #(.STAGES(SYNC_STAGES), .WIDTH(LRS_LINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_raw),
      .q     (level)
   );

   lrs_interval #(.PERIOD(POLL_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (timer_run),
      .tick  (tick)
   );

   lrs_fsm #(.POLL_LIMIT(POLL_LIMIT), .SETTLE(SETTLE), .CW(CW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .level        (level),
      .tick         (tick),
      .timer_run    (timer_run),
      .oe           (oe),
      .drv          (drv),
      .pad_sel_i2c  (pad_sel_i2c),
      .busy         (busy),
      .done         (done),
      .bad          (bad),
      .failed       (failed),
      .polls        (polls),
      .status_valid (status_valid),
      .status_ok    (status_ok)
   );

   assign scl_oe    = oe[LRS_SCL];
   assign sda_oe    = oe[LRS_SDA];
   assign scl_out   = drv[LRS_SCL];
   assign sda_out   = drv[LRS_SDA];
   assign scl_polls = polls[LRS_SCL];
   assign sda_polls = polls[LRS_SDA];
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
   parameter int POLL_LIMIT = 100,
   parameter int CW         = $clog2(POLL_LIMIT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_oe,
   input logic          scl_out,
   input logic          sda_oe,
   input logic          sda_out,
   input logic          pad_sel_i2c,
   input logic          busy,
   input logic          done,
   input logic [1:0]    bad,
   input logic [1:0]    failed,
   input logic [CW-1:0] scl_polls,
   input logic [CW-1:0] sda_polls,
   input logic          status_valid,
   input logic          status_ok
);
   // R1
   single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_oe && sda_oe));

   // R3
   scl_high_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> scl_out);

   // R3
   sda_high_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> sda_out);

   // R3
   scl_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> $past(scl_out));

   // R3
   sda_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(sda_out));

   // R3
   drive_needs_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe |-> bad[0]) and (sda_oe |-> bad[1]));

   // R4
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_polls <= CW'(POLL_LIMIT)) && (sda_polls <= CW'(POLL_LIMIT)));

   // R6
   fail_implies_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (failed & ~bad) == 2'b00);

   // R7
   handback_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_sel_i2c |-> (!scl_oe && !sda_oe));

   // R7
   busy_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pad_sel_i2c);

   // R5
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   // R8
   status_needs_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> (bad != 2'b00));

   // R8
   ok_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_ok |-> (status_valid && failed == 2'b00));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

bind i2c_line_rescue lrs_checker #(.POLL_LIMIT(POLL_LIMIT)) u_lrs_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_oe       (scl_oe),
   .scl_out      (scl_out),
   .sda_oe       (sda_oe),
   .sda_out      (sda_out),
   .pad_sel_i2c  (pad_sel_i2c),
   .busy         (busy),
   .done         (done),
   .bad          (bad),
   .failed       (failed),
   .scl_polls    (scl_polls),
   .sda_polls    (sda_polls),
   .status_valid (status_valid),
   .status_ok    (status_ok)
);

// File: tb/tb_i2c_line_rescue.sv
module tb_i2c_line_rescue;
   localparam int CLK_HZ  = 2_500_000;
   localparam int POLL_US = 4;
   localparam int LIMIT   = 100;
   localparam int P       = (CLK_HZ / 1_000_000) * POLL_US;
   localparam int CW      = $clog2(LIMIT + 1);
   localparam int M_HIGH  = -2;
   localparam int M_NEVER = -1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic scl_in, sda_in;
   logic scl_oe, scl_out, sda_oe, sda_out;
   logic pad_sel_i2c, busy, done, status_valid, status_ok;
   logic [1:0] bad, failed;
   logic [CW-1:0] scl_polls, sda_polls;

   int checks = 0;
   int failures = 0;

   // peripheral model state
   logic hold_scl = 1'b0, hold_sda = 1'b0;
   int   rel_scl = 0, rel_sda = 0;
   int   cyc_scl = 0, cyc_sda = 0;
   int   first_drv = 0;
   int   overlap = 0;
   int   low_drive = 0;
   int   done_seen = 0;

   always #4 clk = ~clk;

   assign scl_in = !(hold_scl || (scl_oe && !scl_out));
   assign sda_in = !(hold_sda || (sda_oe && !sda_out));

   i2c_line_rescue #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US), .POLL_LIMIT(LIMIT),
                     .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .scl_out(scl_out), .sda_oe(sda_oe), .sda_out(sda_out),
      .pad_sel_i2c(pad_sel_i2c), .busy(busy), .done(done),
      .bad(bad), .failed(failed), .scl_polls(scl_polls), .sda_polls(sda_polls),
      .status_valid(status_valid), .status_ok(status_ok)
   );

   always @(negedge clk) begin
      if (done) done_seen <= done_seen + 1;
      if (scl_oe && sda_oe) overlap <= 1;
      if ((scl_oe && !scl_out) || (sda_oe && !sda_out)) low_drive <= 1;
      if (first_drv == 0 && scl_oe) first_drv <= 1;
      else if (first_drv == 0 && sda_oe) first_drv <= 2;
      if (scl_oe && hold_scl) begin
         cyc_scl <= cyc_scl + 1;
         if (rel_scl > 0 && cyc_scl + 1 >= rel_scl) hold_scl <= 1'b0;
      end
      if (sda_oe && hold_sda) begin
         cyc_sda <= cyc_sda + 1;
         if (rel_sda > 0 && cyc_sda + 1 >= rel_sda) hold_sda <= 1'b0;
      end
   end

   function automatic bit exp_bad(int m);
      return m != M_HIGH;
   endfunction
   function automatic bit exp_fail(int m);
      return m == M_NEVER;
   endfunction
   function automatic int exp_cnt(int m);
      return (m > 0) ? m : 0;
   endfunction
   function automatic int rel_cycles(int m);
      return (m > 0) ? (P * m - P / 2) : 0;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_trial(int ms, int md, bit poke);
      int waited;
      bit eb0, eb1, ef0, ef1;
      eb0 = exp_bad(ms); eb1 = exp_bad(md);
      ef0 = exp_fail(ms); ef1 = exp_fail(md);
      @(negedge clk);
      hold_scl = (ms != M_HIGH); hold_sda = (md != M_HIGH);
      rel_scl = rel_cycles(ms); rel_sda = rel_cycles(md);
      cyc_scl = 0; cyc_sda = 0;
      first_drv = 0; overlap = 0; low_drive = 0; done_seen = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R9: busy one cycle after start, pads in pin function (R7)
      check("R9 busy after start", int'(busy), 1);
      check("R7 pin function while busy", int'(pad_sel_i2c), 0);
      waited = 0;
      while (!done && waited < 4 * LIMIT * P + 200) begin
         @(negedge clk);
         waited++;
         if (poke && waited == 40) start = 1'b1;   // R10 start while busy
         else start = 1'b0;
      end
      start = 1'b0;
      if (!done) begin
         check("R9 done reached", 0, 1);
         return;
      end
      check("R3 scl bad", int'(bad[0]), int'(eb0));
      check("R3 sda bad", int'(bad[1]), int'(eb1));
      check("R6 scl failed", int'(failed[0]), int'(ef0));
      check("R6 sda failed", int'(failed[1]), int'(ef1));
      check("R4 scl polls", int'(scl_polls), exp_cnt(ms));
      check("R4 sda polls", int'(sda_polls), exp_cnt(md));
      check("R8 status valid", int'(status_valid), int'(eb0 | eb1));
      check("R8 status ok", int'(status_ok), int'((eb0 | eb1) & !(ef0 | ef1)));
      check("R7 handback", int'(pad_sel_i2c), 1);
      check("R9 busy low with done", int'(busy), 0);
      if (ms == M_HIGH && md == M_HIGH)
         check("R2 no line driven", first_drv, 0);
      else if (ms != M_HIGH)
         check("R1 scl driven first", first_drv, 1);
      else
         check("R2 scl untouched", first_drv, 2);
      check("R1 no overlap", overlap, 0);
      check("R3 no low drive", low_drive, 0);
      repeat (4) @(negedge clk);
      check("R5 drivers off", int'(scl_oe) + int'(sda_oe), 0);
      check("R10 single completion", done_seen, 1);
      check("R10 no restart", int'(busy), 0);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20150821));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 reset pad select", int'(pad_sel_i2c), 0);
      check("R7 reset drivers", int'(scl_oe) + int'(sda_oe), 0);
      check("R9 reset idle", int'(busy) + int'(done), 0);
      check("R8 reset status", int'(status_valid), 0);

      run_trial(M_HIGH, M_HIGH, 1'b0);     // R2 nothing stuck
      run_trial(1, M_HIGH, 1'b0);          // R4 freed at first poll
      run_trial(M_HIGH, LIMIT, 1'b0);      // R4 freed on the last poll
      run_trial(M_NEVER, M_NEVER, 1'b0);   // R6 both stay stuck
      run_trial(3, M_NEVER, 1'b1);         // R10 start while busy
      run_trial(M_NEVER, 7, 1'b0);
      for (int t = 0; t < 14; t++) begin
         int ms, md, k;
         k = $urandom_range(0, 5);
         ms = (k < 2) ? M_HIGH : (k == 2) ? M_NEVER : $urandom_range(1, LIMIT);
         k = $urandom_range(0, 5);
         md = (k < 2) ? M_HIGH : (k == 2) ? M_NEVER : $urandom_range(1, LIMIT);
         run_trial(ms, md, t[0]);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule